// File: doc/BRIEF.md
# Clear-on-Read Receive Error Counter

This block tallies receive-error strobes coming from a receive path and presents the tally on a 16-bit read-data port. Reading the tally also empties it, so a reader that polls at any rate sees the number of errors since its previous poll. The counter stops at its largest value instead of wrapping, so a missed poll never shows up as a small, misleading count.

A write-only configuration bit sets the counter width. A two-state machine holds this bit. `MODE_WIDE` is the reset state and counts across all 16 bits. `MODE_NARROW` counts only in the low byte. A write with bit 0 clear takes the transition `GO_WIDE` to `MODE_WIDE`. A write with bit 0 set takes the transition `GO_NARROW` to `MODE_NARROW`. A write that leaves the state where it is takes the transition `STAY`. The state itself never appears on the read port. Every write also empties the counter, so counting starts from zero in the new width.

Each cycle the counter performs exactly one operation, chosen in priority order. The operations are hold, increment, clear, and restart-at-one.

Top module: `rx_err_tally`

## Requirements
- R1: When an error strobe arrives in a cycle with no read and no write, and the count is below the mode's ceiling, the count rises by exactly one at the next clock edge.
- R2: `rd_data` always shows the current count. A read strobe with no error and no write in the same cycle leaves the count at zero after the edge.
- R3: A write sets the mode from `wr_data` bit 0, where 0 means 16-bit and 1 means 8-bit. All other `wr_data` bits have no effect.
- R4: `rd_data` carries only the count and never the mode bit. In 8-bit mode, `rd_data[15:8]` reads as zero.
- R5: In 16-bit mode the count stops at 65535 (0xFFFF). Further errors leave it there.
- R6: In 8-bit mode the count stops at 255 (0x00FF). Further errors leave it there.
- R7: When an error and a read fall in the same cycle, the read shows the old count and the count becomes 1 after the edge.
- R8: A write empties the counter. An error strobe in the same cycle as the write is dropped, and a read in that cycle shows the old count.
- R9: After reset the count is 0 and the mode is 16-bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| err_pulse | input | 1 | One receive-error event per cycle held high |
| rd_stb | input | 1 | Register read strobe; clears the count |
| wr_stb | input | 1 | Register write strobe |
| wr_data | input | 16 | Write data; bit 0 selects the mode |
| rd_data | output | 16 | Current count as seen by a read |

## Verification
The bench targets the collisions between operations: an error together with a read, an error together with a write, and a read together with a write. A design that gives the wrong operation priority either loses the colliding error or reports a count that is off by one. It drives the counter to both ceilings. A wrapping counter would read 0 after 65535 or 255, and a narrow mode that leaked into the high byte would show 0x0100. It also writes mode words whose upper bits are set and changes mode in the middle of a count. A decoder that looked at the wrong bit, or a write that failed to clear, would carry a stale tally into the new width.

// File: rtl/rxe_pkg.sv
package rxe_pkg;
    typedef enum logic {
        MODE_WIDE   = 1'b0,
        MODE_NARROW = 1'b1
    } rxe_mode_e;

    typedef enum logic [1:0] {
        OP_HOLD    = 2'd0,
        OP_INC     = 2'd1,
        OP_CLEAR   = 2'd2,
        OP_RESTART = 2'd3
    } rxe_op_e;
endpackage

// File: rtl/rxe_mode_fsm.sv
module rxe_mode_fsm
    import rxe_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int MODE_BIT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    output logic              narrow
);
    rxe_mode_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_WIDE;
        else        state_q <= state_d;
    end

    // transitions: GO_WIDE, GO_NARROW, STAY
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_WIDE:   if (wr_stb && wr_data[MODE_BIT])  state_d = MODE_NARROW;
            MODE_NARROW: if (wr_stb && !wr_data[MODE_BIT]) state_d = MODE_WIDE;
            default:     state_d = MODE_WIDE;
        endcase
    end

    // outputs
    always_comb begin
        narrow = 1'b0;
        unique case (state_q)
            MODE_WIDE:   narrow = 1'b0;
            MODE_NARROW: narrow = 1'b1;
            default:     narrow = 1'b0;
        endcase
    end

    p_mode_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> (narrow == $past(wr_data[MODE_BIT])));
    p_mode_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(narrow));
endmodule

// File: rtl/rxe_sat_counter.sv
module rxe_sat_counter
    import rxe_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  rxe_op_e          op,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] cnt_d;
    logic             at_limit;

    assign at_limit = (cnt == limit);

    always_comb begin
        cnt_d = cnt;
        unique case (op)
            OP_HOLD:    cnt_d = cnt;
            OP_INC:     cnt_d = at_limit ? cnt : cnt + CNT_W'(1);
            OP_CLEAR:   cnt_d = '0;
            OP_RESTART: cnt_d = CNT_W'(1);
            default:    cnt_d = cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt_d;
    end

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_INC && at_limit) |=> (cnt == $past(limit)));
endmodule

// File: rtl/rxe_read_view.sv
module rxe_read_view #(
    parameter int CNT_W    = 16,
    parameter int NARROW_W = 8
) (
    input  logic             narrow,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] view
);
    for (genvar i = 0; i < CNT_W; i++) begin : g_bit
        if (i < NARROW_W) begin : g_low
            assign view[i] = cnt[i];
        end else begin : g_high
            assign view[i] = cnt[i] & ~narrow;
        end
    end
endmodule

// File: rtl/rx_err_tally.sv
module rx_err_tally
    import rxe_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int NARROW_W = 8,
    parameter int MODE_BIT = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err_pulse,
    input  logic             rd_stb,
    input  logic             wr_stb,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] rd_data
);
    localparam logic [CNT_W-1:0] WIDE_MAX   = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] NARROW_MAX = CNT_W'((1 << NARROW_W) - 1);

    logic             narrow;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;
    rxe_op_e          op;

    rxe_mode_fsm #(.DATA_W(CNT_W), .MODE_BIT(MODE_BIT)) u_mode (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data), .narrow(narrow)
    );

    assign limit = narrow ? NARROW_MAX : WIDE_MAX;

    // operation select: write > read > error
    always_comb begin
        if (wr_stb)         op = OP_CLEAR;
        else if (rd_stb)    op = err_pulse ? OP_RESTART : OP_CLEAR;
        else if (err_pulse) op = OP_INC;
        else                op = OP_HOLD;
    end

    rxe_sat_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .op(op), .limit(limit), .cnt(cnt)
    );

    rxe_read_view #(.CNT_W(CNT_W), .NARROW_W(NARROW_W)) u_view (
        .narrow(narrow), .cnt(cnt), .view(rd_data)
    );

    p_incr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (err_pulse && !rd_stb && !wr_stb && rd_data != limit)
        |=> (rd_data == $past(rd_data) + CNT_W'(1)));
    p_rd_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !wr_stb && !err_pulse) |=> (rd_data == '0));
    p_hi_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        narrow |-> (rd_data[CNT_W-1:NARROW_W] == '0));
    p_sat_narrow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (narrow && rd_data == NARROW_MAX && err_pulse && !rd_stb && !wr_stb)
        |=> (rd_data == NARROW_MAX));
    p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && err_pulse && !wr_stb) |=> (rd_data == CNT_W'(1)));
    p_wr_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> (rd_data == '0));
endmodule

// File: tb/rx_err_tally_tb.sv
module rx_err_tally_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        err_pulse = 1'b0;
    logic        rd_stb = 1'b0;
    logic        wr_stb = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;

    int n_cmp = 0;
    int n_bad = 0;
    int m_cnt = 0;
    bit m_narrow = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rx_err_tally u_dut (
        .clk(clk), .rst_n(rst_n), .err_pulse(err_pulse), .rd_stb(rd_stb),
        .wr_stb(wr_stb), .wr_data(wr_data), .rd_data(rd_data)
    );

    function automatic int expect_view();
        return m_narrow ? (m_cnt & 255) : m_cnt;
    endfunction

    task automatic compare(string tag);
        n_cmp++;
        if (int'(rd_data) != expect_view()) begin
            n_bad++;
            $display("FAIL %s: rd_data actual=%0d expected=%0d", tag, rd_data, expect_view());
        end
    endtask

    // compare, drive one cycle, advance the model
    task automatic step(string tag, bit e, bit r, bit w, logic [15:0] d);
        int cap;
        @(negedge clk);
        compare(tag);
        err_pulse = e; rd_stb = r; wr_stb = w; wr_data = d;
        @(posedge clk);
        cap = m_narrow ? 255 : 65535;
        if (w) begin
            m_cnt = 0;
            m_narrow = d[0];
        end else if (r) begin
            m_cnt = e ? 1 : 0;
        end else if (e && m_cnt < cap) begin
            m_cnt++;
        end
        #1;
        err_pulse = 1'b0; rd_stb = 1'b0; wr_stb = 1'b0; wr_data = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 190000);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        // R9: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R9");
        rst_n = 1'b1;
        step("R9", 0, 0, 0, 16'h0);
        // R1: a burst of events, then sparse events
        for (int i = 0; i < 10; i++) step("R1", 1, 0, 0, 16'h0);
        for (int i = 0; i < 6; i++) step("R1", i % 2, 0, 0, 16'h0);
        // R2: read shows the count, then zero
        step("R2", 0, 1, 0, 16'h0);
        step("R2", 0, 0, 0, 16'h0);
        for (int i = 0; i < 4; i++) step("R1", 1, 0, 0, 16'h0);
        // R7: error and read together
        step("R7", 1, 1, 0, 16'h0);
        step("R7", 0, 0, 0, 16'h0);
        // R3 and R8: to 8-bit mode with upper bits set, an error in the same cycle
        for (int i = 0; i < 5; i++) step("R1", 1, 0, 0, 16'h0);
        step("R8", 1, 0, 1, 16'hFF01);
        step("R3", 0, 0, 0, 16'h0);
        // R6 and R4: narrow ceiling, high byte stays zero
        for (int i = 0; i < 300; i++) step("R6", 1, 0, 0, 16'h0);
        step("R4", 0, 0, 0, 16'h0);
        step("R2", 0, 1, 0, 16'h0);
        // R8: write together with read shows old count
        for (int i = 0; i < 7; i++) step("R1", 1, 0, 0, 16'h0);
        step("R8", 0, 1, 1, 16'hFFFE);
        step("R3", 0, 0, 0, 16'h0);
        // R3: wide again, count past 255
        for (int i = 0; i < 260; i++) step("R3", 1, 0, 0, 16'h0);
        // R3: write of the same mode still clears
        step("R8", 0, 0, 1, 16'h0000);
        // R5: wide ceiling
        for (int i = 0; i < 65540; i++) step("R5", 1, 0, 0, 16'h0);
        step("R5", 0, 0, 0, 16'h0);
        step("R7", 1, 1, 0, 16'h0);
        step("R2", 0, 1, 0, 16'h0);
        step("R2", 0, 0, 0, 16'h0);
        finish_run();
    end
endmodule